// File: doc/BRIEF.md
# Mezzanine Power Sequencer

This block runs on the host board and decides when a plugged-in mezzanine card may switch on its supplies. It watches a card-present line, two host readiness conditions (logic configured, clocks locked), an enable from the shelf manager and a flag for the bulk supply. From these it drives a single permission line toward the card. It then waits for two status returns from the card: one saying its supplies are in range, and one saying it is configured and ready.

Every signal from the card is treated as meaningless until the supplies-good return is present. Only then does the block qualify the card's inputs, enable the spare outbound drivers and take the card into the JTAG chain. System readiness is reported only once the card also says it is configured. Once permission has been given, it is held until one of a small set of drop events occurs. A re-power request forces a minimum off period before permission returns. A supply return that never arrives raises a timeout fault. All inputs are asynchronous and pass through a synchronizer inside the block.

Top module: `mezz_pwr_seq`

## Requirements
- R1: `mz_permit` rises only from a state in which the synchronized `host_cfg_done` and `host_clk_locked` were both high on the previous cycle, with the card present, `shelf_en` high and `bulk_ok` high.
- R2: While `mz_permit` is high, it stays high regardless of the host readiness inputs and the card's returns. It is cleared only by `shelf_en` low, `bulk_ok` low, card removal or a re-power request.
- R3: `mz_inputs_valid` is high only while the synchronized `mz_supply_good` is high and the sequencer is past the supply wait. `mz_config_ready` has no effect on any output while `mz_supply_good` is low.
- R4: `sys_ready` is high only while `mz_inputs_valid` and the synchronized `mz_config_ready` are both high. It falls within a few cycles of `mz_config_ready` falling.
- R5: `spare_oe` is low (lines tri-stated) whenever the synchronized `mz_supply_good` is low.
- R6: `jtag_bypass` is high (card skipped) whenever the card's inputs are not qualified.
- R7: `card_present_n` is active low. When it goes high, the sequencer returns to idle and `mz_permit` is low on the following cycle.
- R8: After a re-power request, `mz_permit` is low for exactly OFF_CYC+2 cycles, provided the host stays ready and the request has ended, and then rises again.
- R9: If `mz_supply_good` has not arrived, `supply_fault` rises exactly TIMEOUT_CYC+2 cycles after `mz_permit` rises. In the fault state `mz_permit` stays high, and a late `mz_supply_good` is not qualified.
- R10: Each input passes through two synchronizing flops. A host-ready change made between edges shows on `mz_permit` after the third rising edge, not earlier.
- R11: During and after reset, with no card present: `mz_permit`, `mz_inputs_valid`, `sys_ready`, `spare_oe` and `supply_fault` are low and `jtag_bypass` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| card_present_n | input | 1 | Low when the mezzanine is installed |
| host_cfg_done | input | 1 | Host logic is configured |
| host_clk_locked | input | 1 | All host clocks are running |
| shelf_en | input | 1 | Shelf manager allows power |
| bulk_ok | input | 1 | Bulk input supply is present |
| repower_req | input | 1 | Request to cycle the card's power |
| mz_supply_good | input | 1 | Card reports supplies in range |
| mz_config_ready | input | 1 | Card reports configured and ready |
| mz_permit | output | 1 | Permission for the card to power up |
| mz_inputs_valid | output | 1 | Card's other inputs are qualified |
| sys_ready | output | 1 | Host plus card ready for system use |
| spare_oe | output | 1 | Output enable for spare lines toward the card |
| jtag_bypass | output | 1 | Route the JTAG chain around the card |
| supply_fault | output | 1 | Supply return did not arrive in time |

## Verification
The bench builds the sequencer with TIMEOUT_CYC = 20 and OFF_CYC = 12 instead of the million- and hundred-thousand-cycle defaults. With these values, both the exact cycle at which the timeout fault rises and the exact length of the re-power off window can be counted edge by edge in a short run. The synchronizer depth stays at its default of two. This makes the three-edge latency from a host-ready change to permission an exact, checkable number.

// File: rtl/mezz_pwr_pkg.sv
package mezz_pwr_pkg;

    typedef enum logic [2:0] {
        S_IDLE        = 3'd0,
        S_WAIT_HOST   = 3'd1,
        S_PERMIT      = 3'd2,
        S_WAIT_SUPPLY = 3'd3,
        S_WAIT_CONFIG = 3'd4,
        S_RUN         = 3'd5,
        S_REPOWER_OFF = 3'd6,
        S_FAULT       = 3'd7
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
    } seq_reg_t;

    localparam int unsigned NUM_ASYNC = 8;

endpackage

// File: rtl/mps_sync.sv
module mps_sync #(
    parameter int unsigned W       = 1,
    parameter int unsigned STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] stg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(STAGES); i++) stg_q[i] <= RST_VAL;
        end else begin
            stg_q[0] <= d;
            for (int i = 1; i < int'(STAGES); i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q = stg_q[STAGES-1];

endmodule

// File: rtl/mps_timer.sv
module mps_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)             cnt_d = load_val;
        else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/mezz_pwr_seq.sv
module mezz_pwr_seq
    import mezz_pwr_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 1_000_000,
    parameter int unsigned OFF_CYC     = 100_000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic card_present_n,
    input  logic host_cfg_done,
    input  logic host_clk_locked,
    input  logic shelf_en,
    input  logic bulk_ok,
    input  logic repower_req,
    input  logic mz_supply_good,
    input  logic mz_config_ready,
    output logic mz_permit,
    output logic mz_inputs_valid,
    output logic sys_ready,
    output logic spare_oe,
    output logic jtag_bypass,
    output logic supply_fault
);

    localparam int unsigned TMR_MAX = (TIMEOUT_CYC > OFF_CYC) ? TIMEOUT_CYC : OFF_CYC;
    localparam int unsigned TW      = $clog2(TMR_MAX + 1);
    localparam logic [TW-1:0] TMO_VAL = TW'(TIMEOUT_CYC);
    localparam logic [TW-1:0] OFF_VAL = TW'(OFF_CYC);
    // bit 7 is the card-present line, which idles high (absent)
    localparam logic [NUM_ASYNC-1:0] SYNC_RST = 8'b1000_0000;

    // synchronized copies of the asynchronous inputs
    logic card_n_s, cfg_s, lock_s, shelf_s, bulk_s, rep_s, sg_s, cr_s;

    mps_sync #(
        .W      (NUM_ASYNC),
        .STAGES (SYNC_STAGES),
        .RST_VAL(SYNC_RST)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({card_present_n, host_cfg_done, host_clk_locked, shelf_en,
                bulk_ok, repower_req, mz_supply_good, mz_config_ready}),
        .q    ({card_n_s, cfg_s, lock_s, shelf_s,
                bulk_s, rep_s, sg_s, cr_s})
    );

    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_exp;

    mps_timer #(.W(TW)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .expired (tmr_exp)
    );

    seq_reg_t seq_d, seq_q;
    logic     drop, held;

    always_comb begin
        seq_d    = seq_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        drop     = card_n_s | ~shelf_s | ~bulk_s;
        held     = (seq_q.state == S_PERMIT)      || (seq_q.state == S_WAIT_SUPPLY) ||
                   (seq_q.state == S_WAIT_CONFIG) || (seq_q.state == S_RUN) ||
                   (seq_q.state == S_FAULT);

        if (held && drop) begin
            seq_d.state = S_IDLE;
        end else if (held && rep_s) begin
            seq_d.state = S_REPOWER_OFF;
            tmr_load    = 1'b1;
            tmr_val     = OFF_VAL;
        end else begin
            unique case (seq_q.state)
                S_IDLE: begin
                    if (!drop) seq_d.state = S_WAIT_HOST;
                end
                S_WAIT_HOST: begin
                    if (drop)                 seq_d.state = S_IDLE;
                    else if (cfg_s && lock_s) seq_d.state = S_PERMIT;
                end
                S_PERMIT: begin
                    tmr_load    = 1'b1;
                    tmr_val     = TMO_VAL;
                    seq_d.state = S_WAIT_SUPPLY;
                end
                S_WAIT_SUPPLY: begin
                    if (sg_s)         seq_d.state = S_WAIT_CONFIG;
                    else if (tmr_exp) seq_d.state = S_FAULT;
                end
                S_WAIT_CONFIG: begin
                    if (sg_s && cr_s) seq_d.state = S_RUN;
                end
                S_RUN: begin
                    if (!sg_s || !cr_s) seq_d.state = S_WAIT_CONFIG;
                end
                S_REPOWER_OFF: begin
                    if (drop)                  seq_d.state = S_IDLE;
                    else if (tmr_exp && !rep_s) seq_d.state = S_WAIT_HOST;
                end
                S_FAULT: begin
                    seq_d.state = S_FAULT;
                end
                default: seq_d.state = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{state: S_IDLE};
        else        seq_q <= seq_d;
    end

    assign mz_permit       = held;
    assign mz_inputs_valid = sg_s && ((seq_q.state == S_WAIT_CONFIG) || (seq_q.state == S_RUN));
    assign sys_ready       = mz_inputs_valid && cr_s && (seq_q.state == S_RUN);
    assign spare_oe        = mz_inputs_valid;
    assign jtag_bypass     = ~mz_inputs_valid;
    assign supply_fault    = (seq_q.state == S_FAULT);

endmodule

// File: rtl/mezz_pwr_seq_chk.sv
module mezz_pwr_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic card_n_s,
    input logic cfg_s,
    input logic lock_s,
    input logic shelf_s,
    input logic bulk_s,
    input logic rep_s,
    input logic sg_s,
    input logic cr_s,
    input logic mz_permit,
    input logic mz_inputs_valid,
    input logic sys_ready,
    input logic spare_oe,
    input logic jtag_bypass,
    input logic supply_fault
);

    a_r1_permit_after_host: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mz_permit) |-> $past(cfg_s && lock_s && !card_n_s && shelf_s && bulk_s));

    a_r2_permit_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mz_permit && !card_n_s && shelf_s && bulk_s && !rep_s) |=> mz_permit);

    a_r3_valid_needs_supply: assert property (@(posedge clk) disable iff (!rst_n)
        mz_inputs_valid |-> (sg_s && mz_permit));

    a_r4_ready_needs_config: assert property (@(posedge clk) disable iff (!rst_n)
        sys_ready |-> (mz_inputs_valid && cr_s));

    a_r5_spare_tristate: assert property (@(posedge clk) disable iff (!rst_n)
        !sg_s |-> !spare_oe);

    a_r6_jtag_skip: assert property (@(posedge clk) disable iff (!rst_n)
        !mz_inputs_valid |-> jtag_bypass);

    a_r7_card_removed: assert property (@(posedge clk) disable iff (!rst_n)
        card_n_s |=> !mz_permit);

    a_r9_fault_keeps_permit: assert property (@(posedge clk) disable iff (!rst_n)
        supply_fault |-> (mz_permit && !mz_inputs_valid));

endmodule

bind mezz_pwr_seq mezz_pwr_seq_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .card_n_s       (card_n_s),
    .cfg_s          (cfg_s),
    .lock_s         (lock_s),
    .shelf_s        (shelf_s),
    .bulk_s         (bulk_s),
    .rep_s          (rep_s),
    .sg_s           (sg_s),
    .cr_s           (cr_s),
    .mz_permit      (mz_permit),
    .mz_inputs_valid(mz_inputs_valid),
    .sys_ready      (sys_ready),
    .spare_oe       (spare_oe),
    .jtag_bypass    (jtag_bypass),
    .supply_fault   (supply_fault)
);

// File: tb/mezz_pwr_seq_tb.sv
module mezz_pwr_seq_tb;

    localparam int TMO = 20;
    localparam int OFF = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic card_present_n = 1'b1, host_cfg_done = 1'b0, host_clk_locked = 1'b0;
    logic shelf_en = 1'b0, bulk_ok = 1'b0, repower_req = 1'b0;
    logic mz_supply_good = 1'b0, mz_config_ready = 1'b0;
    logic mz_permit, mz_inputs_valid, sys_ready, spare_oe, jtag_bypass, supply_fault;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mezz_pwr_seq #(.TIMEOUT_CYC(TMO), .OFF_CYC(OFF)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .card_present_n(card_present_n), .host_cfg_done(host_cfg_done),
        .host_clk_locked(host_clk_locked), .shelf_en(shelf_en), .bulk_ok(bulk_ok),
        .repower_req(repower_req), .mz_supply_good(mz_supply_good),
        .mz_config_ready(mz_config_ready), .mz_permit(mz_permit),
        .mz_inputs_valid(mz_inputs_valid), .sys_ready(sys_ready),
        .spare_oe(spare_oe), .jtag_bypass(jtag_bypass), .supply_fault(supply_fault)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic t_reset();
        wait_n(2);
        chk("R11 permit in reset", mz_permit, 1'b0);
        rst_n = 1'b1;
        wait_n(4);
        chk("R11 permit", mz_permit, 1'b0);
        chk("R11 valid", mz_inputs_valid, 1'b0);
        chk("R11 sys_ready", sys_ready, 1'b0);
        chk("R11 spare_oe", spare_oe, 1'b0);
        chk("R11 jtag_bypass", jtag_bypass, 1'b1);
        chk("R11 fault", supply_fault, 1'b0);
    endtask

    task automatic t_host_gate();
        card_present_n = 1'b0; shelf_en = 1'b1; bulk_ok = 1'b1;
        host_cfg_done = 1'b1; host_clk_locked = 1'b0;
        wait_n(20);
        chk("R1 no permit without clocks", mz_permit, 1'b0);
    endtask

    task automatic t_sync_latency();
        host_clk_locked = 1'b1;
        wait_n(2);
        chk("R10 permit after 2 edges", mz_permit, 1'b0);
        wait_n(1);
        chk("R10 permit after 3 edges", mz_permit, 1'b1);
        chk("R1 permit with host ready", mz_permit, 1'b1);
    endtask

    task automatic t_gating();
        mz_config_ready = 1'b1;
        wait_n(6);
        chk("R3 config ignored, valid", mz_inputs_valid, 1'b0);
        chk("R3 config ignored, sys_ready", sys_ready, 1'b0);
        chk("R5 spare off", spare_oe, 1'b0);
        chk("R6 jtag bypassed", jtag_bypass, 1'b1);
        mz_supply_good = 1'b1;
        wait_n(6);
        chk("R3 valid with supply", mz_inputs_valid, 1'b1);
        chk("R5 spare on", spare_oe, 1'b1);
        chk("R6 jtag included", jtag_bypass, 1'b0);
        chk("R4 sys_ready", sys_ready, 1'b1);
    endtask

    task automatic t_cfg_drop();
        mz_config_ready = 1'b0;
        wait_n(5);
        chk("R4 ready drops", sys_ready, 1'b0);
        chk("R3 valid kept", mz_inputs_valid, 1'b1);
        mz_config_ready = 1'b1;
        wait_n(5);
        chk("R4 ready back", sys_ready, 1'b1);
    endtask

    task automatic t_hold();
        host_cfg_done = 1'b0; host_clk_locked = 1'b0; mz_supply_good = 1'b0;
        wait_n(40);
        chk("R2 permit held", mz_permit, 1'b1);
        chk("R5 spare off on supply loss", spare_oe, 1'b0);
        chk("R6 bypass on supply loss", jtag_bypass, 1'b1);
        host_cfg_done = 1'b1; host_clk_locked = 1'b1; mz_supply_good = 1'b1;
        wait_n(6);
        chk("R2 run resumes", sys_ready, 1'b1);
    endtask

    task automatic t_shelf_bulk();
        shelf_en = 1'b0;
        wait_n(5);
        chk("R2 shelf off drops permit", mz_permit, 1'b0);
        shelf_en = 1'b1;
        wait_n(10);
        chk("R2 shelf on re-permit", mz_permit, 1'b1);
        bulk_ok = 1'b0;
        wait_n(5);
        chk("R2 bulk loss drops permit", mz_permit, 1'b0);
        bulk_ok = 1'b1;
        wait_n(10);
        chk("R2 bulk back re-permit", sys_ready, 1'b1);
    endtask

    task automatic t_card();
        card_present_n = 1'b1;
        wait_n(5);
        chk("R7 removal drops permit", mz_permit, 1'b0);
        chk("R7 removal drops ready", sys_ready, 1'b0);
        card_present_n = 1'b0;
        wait_n(10);
        chk("R7 reinsert permit", mz_permit, 1'b1);
    endtask

    task automatic t_repower();
        repower_req = 1'b1;
        wait_n(1);
        repower_req = 1'b0;
        wait_n(1);
        chk("R10 request not yet seen", mz_permit, 1'b1);
        wait_n(1);
        chk("R8 permit drops", mz_permit, 1'b0);
        wait_n(OFF + 1);
        chk("R8 still off at OFF+1", mz_permit, 1'b0);
        wait_n(1);
        chk("R8 back on at OFF+2", mz_permit, 1'b1);
    endtask

    task automatic t_timeout();
        card_present_n = 1'b1;
        wait_n(5);
        mz_supply_good = 1'b0; mz_config_ready = 1'b0;
        card_present_n = 1'b0;
        for (int g = 0; g < 50 && !mz_permit; g++) @(negedge clk);
        chk("R9 permit given", mz_permit, 1'b1);
        wait_n(TMO + 1);
        chk("R9 no fault at TMO+1", supply_fault, 1'b0);
        wait_n(1);
        chk("R9 fault at TMO+2", supply_fault, 1'b1);
        chk("R9 permit held in fault", mz_permit, 1'b1);
        mz_supply_good = 1'b1;
        wait_n(6);
        chk("R9 late supply not qualified", mz_inputs_valid, 1'b0);
    endtask

    initial begin
        t_reset();
        t_host_gate();
        t_sync_latency();
        t_gating();
        t_cfg_drop();
        t_hold();
        t_shelf_bulk();
        t_card();
        t_repower();
        t_timeout();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

endmodule